// File: doc/BRIEF.md
# Shared Chip-Enable Volume Selector with Termination Control

Several flash dies can sit behind a single chip-enable line. Each die then needs its own small controller that decides whether a command on the shared bus is meant for it. This block is that controller. During initialization after power-on, configuration writes give the die a volume number and a 16-entry termination mask. From then on the block watches decoded volume-select strobes and remembers which volume is currently active. A selection stays in force until some other volume is addressed.

The block reports whether the die is the selected one, and which array commands it should respond to. For each command it also decides whether the die must switch on its on-die termination while that command's data moves. Termination is requested when the mask bit of the addressed volume is set. If that volume is the die's own, the termination is marked as target termination. If it is another volume, it is marked as non-target termination. The decision is taken once, when the command strobe arrives. Mask writes or new volume selections that happen during a data transfer therefore only take effect from the next command.

Top module: `vodt_ctrl`

## Requirements
- R1: While reset is low and after it is released, `sel_o`, `cmd_resp_o`, `odt_en_o`, `odt_tgt_o` and `odt_ntgt_o` are 0. No volume is active, no own volume is assigned, and the mask is all zero.
- R2: A pulse on `cfg_own_we` makes `cfg_own_vol` the die's volume from the next cycle. Until the first such write the die is never selected, whatever volume is active.
- R3: A pulse on `vsel_vld` makes `vsel_vol` the active volume from the next cycle, and that volume stays active until another pulse. `sel_o` is 1 exactly when a volume is active, an own volume is assigned, and the two are equal.
- R4: `cmd_resp_o` is 1 in the same cycle as `cmd_vld` when `sel_o` is 1 in that cycle, and 0 otherwise.
- R5: A pulse on `cfg_mask_we` writes `cfg_mask_byte` into mask byte `cfg_mask_sel`. Byte 0 bit n covers volume n for n = 0..7, and byte 1 bit n covers volume 8+n. Other bytes keep their value.
- R6: A `cmd_vld` pulse arms termination when a volume was active before that cycle and the mask bit of that volume is set. The mask used is its value before that cycle. The decision holds until the next `cmd_vld`. `odt_en_o` is 1 exactly while `data_phase` is 1 and termination is armed.
- R7: When `odt_en_o` is 1, `odt_tgt_o` is 1 if the die was selected in the cycle of the arming command, and `odt_ntgt_o` is 1 otherwise. Both are 0 when `odt_en_o` is 0.
- R8: With an all-zero mask at the time of the command, `odt_en_o` stays 0 through every data phase of that command.
- R9: Mask writes and volume selections made after a command do not change `odt_en_o`, `odt_tgt_o` or `odt_ntgt_o` until the next `cmd_vld`.
- R10: Commands issued before the first volume select after reset never turn termination on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_own_we | input | 1 | Write strobe for the die's own volume |
| cfg_own_vol | input | VOL_W (4) | Own volume number |
| cfg_mask_we | input | 1 | Write strobe for one termination mask byte |
| cfg_mask_sel | input | SEL_W (1) | Mask byte index |
| cfg_mask_byte | input | 8 | Mask byte value |
| vsel_vld | input | 1 | Decoded volume-select strobe |
| vsel_vol | input | VOL_W (4) | Volume addressed by the select |
| cmd_vld | input | 1 | Decoded command strobe |
| data_phase | input | 1 | High while command data is on the bus |
| sel_o | output | 1 | Die owns the active volume |
| cmd_resp_o | output | 1 | Die responds to the command in this cycle |
| odt_en_o | output | 1 | Enable on-die termination |
| odt_tgt_o | output | 1 | Termination is for the die's own volume |
| odt_ntgt_o | output | 1 | Termination is for another volume |

## Verification
The assertions take the strobes as single-cycle decoded events sampled on the clock. They also assume that reset is low at time zero. They place no rule on overlap, so a select, a command and a mask write may all arrive in the same cycle. The stimulus covers both the directed sequences and a long random phase that makes such overlaps, including writes during data phases. In an overlapping cycle, the reference model applies the command against the volume and mask that held before that cycle, as the requirements define.

// File: rtl/vodt_pkg.sv
package vodt_pkg;

  // Termination decision captured at each command strobe
  typedef struct packed {
    logic armed;   // mask bit of the addressed volume was set
    logic own;     // addressed volume was this die's volume
  } term_dec_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/vodt_cfg.sv
module vodt_cfg #(
  parameter int unsigned VOL_W = 4,
  localparam int unsigned NUM_VOL    = 1 << VOL_W,
  localparam int unsigned MASK_BYTES = NUM_VOL / vodt_pkg::BYTE_W,
  localparam int unsigned SEL_W      = (MASK_BYTES > 1) ? $clog2(MASK_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_own_we,
  input  logic [VOL_W-1:0]   cfg_own_vol,
  input  logic               cfg_mask_we,
  input  logic [SEL_W-1:0]   cfg_mask_sel,
  input  logic [7:0]         cfg_mask_byte,
  output logic               own_vld,
  output logic [VOL_W-1:0]   own_vol,
  output logic [NUM_VOL-1:0] mask
);

  logic             own_vld_q, own_vld_d;
  logic [VOL_W-1:0] own_vol_q, own_vol_d;

  always_comb begin
    own_vld_d = own_vld_q;
    own_vol_d = own_vol_q;
    if (cfg_own_we) begin
      own_vld_d = 1'b1;
      own_vol_d = cfg_own_vol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_vol_q <= '0;
    end else if (cfg_own_we) begin
      own_vld_q <= own_vld_d;
      own_vol_q <= own_vol_d;
    end
  end

  assign own_vld = own_vld_q;
  assign own_vol = own_vol_q;

  // One independently enabled register per mask byte
  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_mask_byte
    logic       byte_en;
    logic [7:0] byte_q;
    logic [7:0] byte_d;

    always_comb begin
      byte_en = cfg_mask_we && (cfg_mask_sel == SEL_W'(b));
      byte_d  = byte_en ? cfg_mask_byte : byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= byte_d;
      end
    end

    assign mask[b*8 +: 8] = byte_q;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mask_we |=> $stable(mask)); // R5

  AST_OWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_own_we |=> $stable(own_vol) && $stable(own_vld)); // R2

endmodule

// File: rtl/vodt_track.sv
module vodt_track #(
  parameter int unsigned VOL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsel_vld,
  input  logic [VOL_W-1:0] vsel_vol,
  input  logic             own_vld,
  input  logic [VOL_W-1:0] own_vol,
  output logic             act_vld,
  output logic [VOL_W-1:0] act_vol,
  output logic             sel
);

  logic             act_vld_q, act_vld_d;
  logic [VOL_W-1:0] act_vol_q, act_vol_d;

  always_comb begin
    act_vld_d = act_vld_q;
    act_vol_d = act_vol_q;
    if (vsel_vld) begin
      act_vld_d = 1'b1;
      act_vol_d = vsel_vol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_vld_q <= 1'b0;
      act_vol_q <= '0;
    end else if (vsel_vld) begin
      act_vld_q <= act_vld_d;
      act_vol_q <= act_vol_d;
    end
  end

  assign act_vld = act_vld_q;
  assign act_vol = act_vol_q;
  assign sel     = act_vld_q && own_vld && (act_vol_q == own_vol);

  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !vsel_vld |=> $stable(act_vol) && $stable(act_vld)); // R3

  AST_SELECT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    vsel_vld |=> act_vld); // R3

endmodule

// File: rtl/vodt_term.sv
module vodt_term #(
  parameter int unsigned VOL_W = 4,
  localparam int unsigned NUM_VOL = 1 << VOL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_vld,
  input  logic               act_vld,
  input  logic [VOL_W-1:0]   act_vol,
  input  logic               sel,
  input  logic [NUM_VOL-1:0] mask,
  input  logic               data_phase,
  output logic               odt_en,
  output logic               odt_tgt,
  output logic               odt_ntgt
);
  import vodt_pkg::*;

  term_dec_t dec_q, dec_d;

  always_comb begin
    dec_d = dec_q;
    if (cmd_vld) begin
      dec_d.armed = act_vld && mask[act_vol];
      dec_d.own   = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= '0;
    end else if (cmd_vld) begin
      dec_q <= dec_d;
    end
  end

  assign odt_en   = dec_q.armed && data_phase;
  assign odt_tgt  = odt_en && dec_q.own;
  assign odt_ntgt = odt_en && !dec_q.own;

  AST_ZERO_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && (mask == '0) |=> !dec_q.armed); // R8

  AST_HOLD_TO_NEXT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> $stable(dec_q)); // R9

  AST_NO_VOL_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && !act_vld |=> !dec_q.armed); // R10

endmodule

// File: rtl/vodt_ctrl.sv
module vodt_ctrl #(
  parameter int unsigned VOL_W = 4,
  localparam int unsigned NUM_VOL    = 1 << VOL_W,
  localparam int unsigned MASK_BYTES = NUM_VOL / vodt_pkg::BYTE_W,
  localparam int unsigned SEL_W      = (MASK_BYTES > 1) ? $clog2(MASK_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_own_we,
  input  logic [VOL_W-1:0] cfg_own_vol,
  input  logic             cfg_mask_we,
  input  logic [SEL_W-1:0] cfg_mask_sel,
  input  logic [7:0]       cfg_mask_byte,
  input  logic             vsel_vld,
  input  logic [VOL_W-1:0] vsel_vol,
  input  logic             cmd_vld,
  input  logic             data_phase,
  output logic             sel_o,
  output logic             cmd_resp_o,
  output logic             odt_en_o,
  output logic             odt_tgt_o,
  output logic             odt_ntgt_o
);

  logic               own_vld;
  logic [VOL_W-1:0]   own_vol;
  logic [NUM_VOL-1:0] mask;
  logic               act_vld;
  logic [VOL_W-1:0]   act_vol;
  logic               sel;

  vodt_cfg #(.VOL_W(VOL_W)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_own_we    (cfg_own_we),
    .cfg_own_vol   (cfg_own_vol),
    .cfg_mask_we   (cfg_mask_we),
    .cfg_mask_sel  (cfg_mask_sel),
    .cfg_mask_byte (cfg_mask_byte),
    .own_vld       (own_vld),
    .own_vol       (own_vol),
    .mask          (mask)
  );

  vodt_track #(.VOL_W(VOL_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsel_vld (vsel_vld),
    .vsel_vol (vsel_vol),
    .own_vld  (own_vld),
    .own_vol  (own_vol),
    .act_vld  (act_vld),
    .act_vol  (act_vol),
    .sel      (sel)
  );

  vodt_term #(.VOL_W(VOL_W)) u_term (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_vld    (cmd_vld),
    .act_vld    (act_vld),
    .act_vol    (act_vol),
    .sel        (sel),
    .mask       (mask),
    .data_phase (data_phase),
    .odt_en     (odt_en_o),
    .odt_tgt    (odt_tgt_o),
    .odt_ntgt   (odt_ntgt_o)
  );

  assign sel_o      = sel;
  assign cmd_resp_o = cmd_vld && sel;

  AST_ODT_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    odt_en_o |-> data_phase); // R6

  AST_ROLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({odt_tgt_o, odt_ntgt_o})); // R7

  AST_ROLE_NEEDS_ODT: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_tgt_o || odt_ntgt_o) |-> odt_en_o); // R7

  AST_RESP_ONLY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_resp_o |-> sel_o && cmd_vld); // R4

endmodule

// File: tb/tb_vodt_ctrl.sv
module tb_vodt_ctrl;

  localparam int VOL_W = 4;
  localparam int NV    = 1 << VOL_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_own_we, cfg_mask_we, vsel_vld, cmd_vld, data_phase;
  logic [VOL_W-1:0] cfg_own_vol, vsel_vol;
  logic [0:0]       cfg_mask_sel;
  logic [7:0]       cfg_mask_byte;
  logic             sel_o, cmd_resp_o, odt_en_o, odt_tgt_o, odt_ntgt_o;

  always #2 clk = ~clk;

  vodt_ctrl #(.VOL_W(VOL_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_own_we(cfg_own_we), .cfg_own_vol(cfg_own_vol),
    .cfg_mask_we(cfg_mask_we), .cfg_mask_sel(cfg_mask_sel), .cfg_mask_byte(cfg_mask_byte),
    .vsel_vld(vsel_vld), .vsel_vol(vsel_vol),
    .cmd_vld(cmd_vld), .data_phase(data_phase),
    .sel_o(sel_o), .cmd_resp_o(cmd_resp_o), .odt_en_o(odt_en_o),
    .odt_tgt_o(odt_tgt_o), .odt_ntgt_o(odt_ntgt_o)
  );

  // Behavioural reference state
  int          m_own, m_act;
  bit [NV-1:0] m_mask;
  bit          m_term, m_tgt;
  int          n_cmp = 0, n_bad = 0, cyc = 0;
  bit          done = 0;
  string       phase = "R1";

  task automatic chk(string req, logic got, logic exp, string name);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] cycle %0d %s: got %0b expected %0b", req, phase, cyc, name, got, exp);
    end
  endtask

  task automatic compare();
    bit e_sel, e_odt;
    e_sel = (m_act >= 0) && (m_own >= 0) && (m_own == m_act);
    e_odt = m_term && data_phase;
    chk((rst_n ? "R3" : "R1"), sel_o, e_sel, "sel_o");
    chk("R4", cmd_resp_o, cmd_vld && e_sel, "cmd_resp_o");
    chk("R6", odt_en_o, e_odt, "odt_en_o");
    chk("R7", odt_tgt_o, e_odt && m_tgt, "odt_tgt_o");
    chk("R7", odt_ntgt_o, e_odt && !m_tgt, "odt_ntgt_o");
  endtask

  task automatic model_update();
    if (!rst_n) begin
      m_own = -1; m_act = -1; m_mask = '0; m_term = 0; m_tgt = 0;
    end else begin
      if (cmd_vld) begin
        m_term = (m_act >= 0) && m_mask[m_act];
        m_tgt  = (m_act >= 0) && (m_own == m_act);
      end
      if (cfg_mask_we) m_mask[int'(cfg_mask_sel)*8 +: 8] = cfg_mask_byte;
      if (vsel_vld)    m_act = int'(vsel_vol);
      if (cfg_own_we)  m_own = int'(cfg_own_vol);
    end
  endtask

  // Called just after a falling edge with inputs driven
  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_update();
    cyc++;
    @(negedge clk);
    cfg_own_we = 0; cfg_mask_we = 0; vsel_vld = 0; cmd_vld = 0;
  endtask

  task automatic wr_mask(int idx, logic [7:0] v);
    cfg_mask_we = 1; cfg_mask_sel = idx[0:0]; cfg_mask_byte = v; tick();
  endtask

  task automatic vsel(int v);
    vsel_vld = 1; vsel_vol = v[VOL_W-1:0]; tick();
  endtask

  task automatic cmd_with_data(int n);
    cmd_vld = 1; tick();
    data_phase = 1;
    for (int i = 0; i < n; i++) tick();
    data_phase = 0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hang expected end");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_own_we = 0; cfg_own_vol = '0; cfg_mask_we = 0; cfg_mask_sel = '0;
    cfg_mask_byte = '0; vsel_vld = 0; vsel_vol = '0; cmd_vld = 0; data_phase = 0;
    m_own = -1; m_act = -1; m_mask = '0; m_term = 0; m_tgt = 0;
    @(negedge clk);
    // R1: reset state, also with strobes active during reset
    phase = "R1";
    tick(); vsel_vld = 1; cmd_vld = 1; data_phase = 1; tick(); data_phase = 0;
    rst_n = 1; tick(); tick();

    // R10: full mask, commands before any select
    phase = "R10";
    wr_mask(0, 8'hFF); wr_mask(1, 8'hFF);
    cmd_with_data(3);

    // R2: select before own volume assigned
    phase = "R2";
    vsel(5); tick(); cmd_with_data(2);
    cfg_own_we = 1; cfg_own_vol = 4'd5; tick(); tick();

    // R3/R4/R7: selected, target termination
    phase = "R3";
    cmd_with_data(2);
    vsel(6); tick(); vsel(5); tick();

    // R5: sparse mask, sweep every volume
    phase = "R5";
    wr_mask(0, 8'h24); wr_mask(1, 8'h81);
    for (int v = 0; v < NV; v++) begin
      vsel(v);
      cmd_with_data(2);
    end

    // R9: changes during a data phase wait for the next command
    phase = "R9";
    vsel(2); cmd_vld = 1; tick(); data_phase = 1; tick();
    wr_mask(0, 8'h00); vsel(9); tick();
    data_phase = 0; tick();
    cmd_with_data(2);
    vsel(5); cmd_vld = 1; tick(); data_phase = 1;
    wr_mask(1, 8'h00); tick(); data_phase = 0; tick();

    // R8: all-zero mask
    phase = "R8";
    wr_mask(0, 8'h00); wr_mask(1, 8'h00);
    for (int v = 0; v < NV; v++) begin
      vsel(v);
      cmd_with_data(1);
    end

    // R6: random overlapping traffic
    phase = "R6";
    for (int i = 0; i < 4000; i++) begin
      vsel_vld      = ($urandom_range(0, 5) == 0);
      vsel_vol      = VOL_W'($urandom_range(0, NV - 1));
      cmd_vld       = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) data_phase = ~data_phase;
      cfg_mask_we   = ($urandom_range(0, 19) == 0);
      cfg_mask_sel  = 1'($urandom_range(0, 1));
      cfg_mask_byte = 8'($urandom_range(0, 255));
      cfg_own_we    = ($urandom_range(0, 99) == 0);
      cfg_own_vol   = VOL_W'($urandom_range(0, NV - 1));
      tick();
    end
    data_phase = 0; tick();
    finish_run();
  end

endmodule